// File: doc/BRIEF.md
# Lossless Pulse-Capture Message Encoder

This block sits between a market-data message parser and the write port of an asynchronous FIFO. The parser announces each finished message with a single-cycle pulse on one of five per-type valid lines and holds the decoded fields on shared buses. The encoder turns each announced message into one fixed 324-bit record. The record is a 4-bit type code on top of 320 bits of packed field data. It offers the record to the FIFO through a write strobe, which is qualified by the FIFO full flag.

A pulse lasts only one cycle, and the FIFO may be stalled when it arrives. For that reason the block has two internal slots. The capture slot always takes an arriving message. The holding slot keeps the older message until the FIFO has room. Writes are served oldest first, so records leave in arrival order. A message is lost only when both slots are occupied, no write happens, and another message arrives. In that case the newest message takes the capture slot, the older captured message is discarded, and the loss is reported three ways: a one-cycle drop pulse, a saturating 16-bit drop counter, and a sticky loss flag that only reset clears.

Top module: `msg_capture_encoder`

## Requirements
- R1: A written word carries the message type code in bits 323:320 (add=1, execute=2, cancel=3, system event=4, directory=5; 0 is never written) and the packed payload in bits 319:0.
- R2: Payload fields are packed from bit 319 downward and every unused bit is zero. Add: reference(64), side(8), quantity(32), symbol(64), price(32). Execute: reference(64), quantity(32), match number(64). Cancel: reference(64), quantity(32). System event: event code(8). Directory: symbol(64), market category(8), financial status(8), lot size(32).
- R3: `fifo_wr` is high only while `fifo_full` is low, and it writes at most one word per clock. A message that arrives while both slots are empty and the FIFO has room is written in the next cycle.
- R4: Words are written in the order their messages arrived: the holding slot is served before the capture slot.
- R5: While the FIFO stays full, two messages are kept without loss and are written once the full flag drops.
- R6: A message that arrives while both slots are occupied and no write happens replaces the message in the capture slot. In the cycle after that arrival, `drop_pulse` is high for exactly one cycle.
- R7: `drop_count` increases by one for each drop and saturates at 0xFFFF.
- R8: `drop_sticky` sets on the first drop and stays set until reset.
- R9: When several valid lines pulse in the same cycle, only the message with the lowest type code is kept.
- R10: After reset no word is written, and `drop_pulse`, `drop_count` and `drop_sticky` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| add_vld | input | 1 | Add-order message pulse |
| exec_vld | input | 1 | Execution message pulse |
| cancel_vld | input | 1 | Cancel message pulse |
| sysevt_vld | input | 1 | System event message pulse |
| stkdir_vld | input | 1 | Directory message pulse |
| f_ref | input | 64 | Order reference |
| f_side | input | 8 | Buy/sell indicator |
| f_qty | input | 32 | Share quantity (added, executed or cancelled) |
| f_symbol | input | 64 | Symbol, ASCII |
| f_price | input | 32 | Price |
| f_match | input | 64 | Match number |
| f_event | input | 8 | System event code |
| f_mkt_cat | input | 8 | Market category |
| f_fin_stat | input | 8 | Financial status |
| f_lot | input | 32 | Round lot size |
| fifo_full | input | 1 | FIFO full flag |
| fifo_wr | output | 1 | FIFO write strobe |
| fifo_wdata | output | 324 | FIFO write word |
| drop_pulse | output | 1 | One-cycle loss indication |
| drop_count | output | 16 | Saturating loss counter |
| drop_sticky | output | 1 | Loss flag, cleared only by reset |

## Verification
A wrong slot state shows up at the ports in one of three ways. If a slot is lost, the next written word differs from the expected word. If a slot is stuck, `fifo_wr` stays high after the data has drained. If a slot is counted wrongly, `drop_pulse` appears when it should not, or fails to appear, in the cycle after the third arrival while the FIFO is full. The bench keeps an arrival-ordered queue with two entries and compares every output on every clock, so a divergence is reported within one cycle. Saturation of the counter is reached by driving more than 65,535 consecutive drops.

// File: rtl/msgenc_pkg.sv
package msgenc_pkg;

    localparam int TYPE_W    = 4;
    localparam int BODY_W    = 320;
    localparam int WORD_W    = TYPE_W + BODY_W;
    localparam int NUM_KINDS = 5;

    typedef enum logic [TYPE_W-1:0] {
        MT_NONE   = 4'd0,
        MT_ADD    = 4'd1,
        MT_EXEC   = 4'd2,
        MT_CANCEL = 4'd3,
        MT_SYSEVT = 4'd4,
        MT_STKDIR = 4'd5
    } msg_kind_e;

    typedef struct packed {
        msg_kind_e          kind;
        logic [BODY_W-1:0]  body;
    } fifo_word_t;

    typedef struct packed {
        logic [63:0] ref_num;
        logic [7:0]  side;
        logic [31:0] qty;
        logic [63:0] symbol;
        logic [31:0] price;
        logic [63:0] match_num;
        logic [7:0]  event_code;
        logic [7:0]  mkt_cat;
        logic [7:0]  fin_stat;
        logic [31:0] lot_size;
    } msg_fields_t;

    // Fields are placed from the top bit downward; the rest stays zero.
    function automatic logic [BODY_W-1:0] pack_body(msg_kind_e k, msg_fields_t f);
        logic [BODY_W-1:0] b;
        b = '0;
        case (k)
            MT_ADD:    b[BODY_W-1 -: 200] = {f.ref_num, f.side, f.qty, f.symbol, f.price};
            MT_EXEC:   b[BODY_W-1 -: 160] = {f.ref_num, f.qty, f.match_num};
            MT_CANCEL: b[BODY_W-1 -: 96]  = {f.ref_num, f.qty};
            MT_SYSEVT: b[BODY_W-1 -: 8]   = f.event_code;
            MT_STKDIR: b[BODY_W-1 -: 112] = {f.symbol, f.mkt_cat, f.fin_stat, f.lot_size};
            default:   b = '0;
        endcase
        return b;
    endfunction

endpackage

// File: rtl/msgenc_select.sv
module msgenc_select
    import msgenc_pkg::*;
#(
    parameter int N = NUM_KINDS
) (
    input  logic [N-1:0] vld,
    input  msg_fields_t  fields,
    output logic         hit,
    output fifo_word_t   word
);
    msg_kind_e kind;

    // Walk from the highest index down so the lowest code wins.
    always_comb begin
        kind = MT_NONE;
        hit  = 1'b0;
        for (int i = N - 1; i >= 0; i--) begin
            if (vld[i]) begin
                kind = msg_kind_e'(TYPE_W'(i + 1));
                hit  = 1'b1;
            end
        end
    end

    always_comb begin
        word.kind = kind;
        word.body = pack_body(kind, fields);
    end
endmodule

// File: rtl/msgenc_stages.sv
module msgenc_stages
    import msgenc_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       in_vld,
    input  fifo_word_t in_word,
    input  logic       fifo_full,
    output logic       wr_en,
    output fifo_word_t wr_word,
    output logic       drop
);
    fifo_word_t hold_q, cap_q;
    logic       hold_v, cap_v;
    logic       hold_keep, cap_keep;

    always_comb begin
        wr_en     = !fifo_full && (hold_v || cap_v);
        wr_word   = hold_v ? hold_q : cap_q;
        hold_keep = hold_v && !wr_en;
        cap_keep  = cap_v && !(wr_en && !hold_v);
        drop      = in_vld && hold_keep && cap_keep;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            hold_v <= 1'b0;
            cap_v  <= 1'b0;
            hold_q <= '0;
            cap_q  <= '0;
        end else begin
            if (!hold_keep && cap_keep) begin
                hold_q <= cap_q;
                hold_v <= 1'b1;
                cap_v  <= in_vld;
            end else begin
                hold_v <= hold_keep;
                cap_v  <= in_vld || cap_keep;
            end
            if (in_vld) begin
                cap_q <= in_word;
            end
        end
    end
endmodule

// File: rtl/msgenc_loss.sv
module msgenc_loss #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             drop,
    output logic             pulse,
    output logic [CNT_W-1:0] count,
    output logic             sticky
);
    localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

    always_ff @(posedge clk) begin
        if (rst) begin
            pulse  <= 1'b0;
            count  <= '0;
            sticky <= 1'b0;
        end else begin
            pulse <= drop;
            if (drop) begin
                sticky <= 1'b1;
                if (count != CNT_MAX) begin
                    count <= count + 1'b1;
                end
            end
        end
    end
endmodule

// File: rtl/msg_capture_encoder.sv
module msg_capture_encoder
    import msgenc_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                add_vld,
    input  logic                exec_vld,
    input  logic                cancel_vld,
    input  logic                sysevt_vld,
    input  logic                stkdir_vld,
    input  logic [63:0]         f_ref,
    input  logic [7:0]          f_side,
    input  logic [31:0]         f_qty,
    input  logic [63:0]         f_symbol,
    input  logic [31:0]         f_price,
    input  logic [63:0]         f_match,
    input  logic [7:0]          f_event,
    input  logic [7:0]          f_mkt_cat,
    input  logic [7:0]          f_fin_stat,
    input  logic [31:0]         f_lot,
    input  logic                fifo_full,
    output logic                fifo_wr,
    output logic [WORD_W-1:0]   fifo_wdata,
    output logic                drop_pulse,
    output logic [CNT_W-1:0]    drop_count,
    output logic                drop_sticky
);
    msg_fields_t         fields;
    logic [NUM_KINDS-1:0] vld_vec;
    logic                new_hit;
    fifo_word_t          new_word;
    fifo_word_t          out_word;
    logic                drop_now;

    assign vld_vec = {stkdir_vld, sysevt_vld, cancel_vld, exec_vld, add_vld};

    always_comb begin
        fields.ref_num    = f_ref;
        fields.side       = f_side;
        fields.qty        = f_qty;
        fields.symbol     = f_symbol;
        fields.price      = f_price;
        fields.match_num  = f_match;
        fields.event_code = f_event;
        fields.mkt_cat    = f_mkt_cat;
        fields.fin_stat   = f_fin_stat;
        fields.lot_size   = f_lot;
    end

    msgenc_select #(.N(NUM_KINDS)) sel_i (
        .vld    (vld_vec),
        .fields (fields),
        .hit    (new_hit),
        .word   (new_word)
    );

    msgenc_stages stg_i (
        .clk       (clk),
        .rst       (rst),
        .in_vld    (new_hit),
        .in_word   (new_word),
        .fifo_full (fifo_full),
        .wr_en     (fifo_wr),
        .wr_word   (out_word),
        .drop      (drop_now)
    );

    assign fifo_wdata = out_word;

    msgenc_loss #(.CNT_W(CNT_W)) loss_i (
        .clk    (clk),
        .rst    (rst),
        .drop   (drop_now),
        .pulse  (drop_pulse),
        .count  (drop_count),
        .sticky (drop_sticky)
    );
endmodule

// File: rtl/msgenc_chk.sv
module msgenc_chk #(
    parameter int CNT_W = 16
) (
    input logic             clk,
    input logic             rst,
    input logic             fifo_full,
    input logic             fifo_wr,
    input logic [3:0]       wtype,
    input logic [311:0]     wtail,
    input logic             drop_pulse,
    input logic [CNT_W-1:0] drop_count,
    input logic             drop_sticky
);
    localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

    // R3
    wr_gated_chk: assert property (@(posedge clk) disable iff (rst)
        fifo_wr |-> !fifo_full);

    // R1
    code_range_chk: assert property (@(posedge clk) disable iff (rst)
        fifo_wr |-> (wtype >= 4'd1 && wtype <= 4'd5));

    // R2
    event_pad_chk: assert property (@(posedge clk) disable iff (rst)
        (fifo_wr && wtype == 4'd4) |-> (wtail == '0));

    // R6
    drop_no_write_chk: assert property (@(posedge clk) disable iff (rst)
        drop_pulse |-> !$past(fifo_wr));

    // R7
    count_step_chk: assert property (@(posedge clk) disable iff (rst)
        drop_pulse |-> (drop_count == CNT_W'($past(drop_count) + 1'b1)) ||
                       ($past(drop_count) == CNT_MAX && drop_count == CNT_MAX));

    // R7
    count_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !drop_pulse |-> $stable(drop_count));

    // R8
    sticky_keep_chk: assert property (@(posedge clk) disable iff (rst)
        $past(drop_sticky) |-> drop_sticky);

    // R8
    sticky_set_chk: assert property (@(posedge clk) disable iff (rst)
        drop_pulse |-> drop_sticky);
endmodule

bind msg_capture_encoder msgenc_chk #(.CNT_W(CNT_W)) chk_i (
    .clk         (clk),
    .rst         (rst),
    .fifo_full   (fifo_full),
    .fifo_wr     (fifo_wr),
    .wtype       (fifo_wdata[323:320]),
    .wtail       (fifo_wdata[311:0]),
    .drop_pulse  (drop_pulse),
    .drop_count  (drop_count),
    .drop_sticky (drop_sticky)
);

// File: tb/msg_capture_encoder_tb_top.sv
module msg_capture_encoder_tb_top;

    logic         clk = 1'b0;
    logic         rst;
    logic [4:0]   vld;
    logic [63:0]  b_ref, b_symbol, b_match;
    logic [7:0]   b_side, b_event, b_mkt, b_fin;
    logic [31:0]  b_qty, b_price, b_lot;
    logic         full;
    logic         fifo_wr;
    logic [323:0] fifo_wdata;
    logic         drop_pulse;
    logic [15:0]  drop_count;
    logic         drop_sticky;

    always #2 clk = ~clk;

    msg_capture_encoder dut_i (
        .clk(clk), .rst(rst),
        .add_vld(vld[0]), .exec_vld(vld[1]), .cancel_vld(vld[2]),
        .sysevt_vld(vld[3]), .stkdir_vld(vld[4]),
        .f_ref(b_ref), .f_side(b_side), .f_qty(b_qty), .f_symbol(b_symbol),
        .f_price(b_price), .f_match(b_match), .f_event(b_event),
        .f_mkt_cat(b_mkt), .f_fin_stat(b_fin), .f_lot(b_lot),
        .fifo_full(full), .fifo_wr(fifo_wr), .fifo_wdata(fifo_wdata),
        .drop_pulse(drop_pulse), .drop_count(drop_count), .drop_sticky(drop_sticky)
    );

    int unsigned  checks = 0;
    int unsigned  fails  = 0;
    string        phase  = "R10 reset";

    logic [323:0] q[$];
    bit           m_drop   = 0;
    int unsigned  m_count  = 0;
    bit           m_sticky = 0;

    function automatic logic [323:0] build_word(input logic [4:0] v);
        logic [319:0] b;
        logic [3:0]   c;
        c = 4'd0;
        b = '0;
        if (v[0])      begin c = 4'd1; b = {b_ref, b_side, b_qty, b_symbol, b_price, 120'b0}; end
        else if (v[1]) begin c = 4'd2; b = {b_ref, b_qty, b_match, 160'b0}; end
        else if (v[2]) begin c = 4'd3; b = {b_ref, b_qty, 224'b0}; end
        else if (v[3]) begin c = 4'd4; b = {b_event, 312'b0}; end
        else if (v[4]) begin c = 4'd5; b = {b_symbol, b_mkt, b_fin, b_lot, 208'b0}; end
        return {c, b};
    endfunction

    task automatic check_bit(input string req, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s [%s]: got %0b expected %0b", req, phase, act, exp);
        end
    endtask

    task automatic compare();
        bit exp_wr;
        exp_wr = (q.size() > 0) && !full;
        check_bit("R3 write strobe", fifo_wr, exp_wr);
        if (exp_wr) begin
            checks++;
            if (fifo_wdata !== q[0]) begin
                fails++;
                $display("FAIL R1/R2/R4 word [%s]: got %h expected %h", phase, fifo_wdata, q[0]);
            end
        end
        check_bit("R6 drop pulse", drop_pulse, m_drop);
        check_bit("R8 sticky", drop_sticky, m_sticky);
        checks++;
        if (drop_count !== 16'(m_count)) begin
            fails++;
            $display("FAIL R7 count [%s]: got %0d expected %0d", phase, drop_count, m_count);
        end
    endtask

    task automatic randomize_fields();
        b_ref = {$urandom, $urandom};   b_symbol = {$urandom, $urandom};
        b_match = {$urandom, $urandom}; b_side = 8'($urandom);
        b_event = 8'($urandom);         b_mkt = 8'($urandom);
        b_fin = 8'($urandom);           b_qty = $urandom;
        b_price = $urandom;             b_lot = $urandom;
    endtask

    task automatic step(input logic [4:0] v, input bit f);
        bit wr_now;
        @(negedge clk);
        vld  = v;
        full = f;
        randomize_fields();
        #1;
        compare();
        wr_now = (q.size() > 0) && !full;
        @(posedge clk);
        if (wr_now) void'(q.pop_front());
        m_drop = 0;
        if (v != 0) begin
            if (q.size() == 2) begin
                q[1]   = build_word(v);
                m_drop = 1;
                m_sticky = 1;
                if (m_count < 65535) m_count++;
            end else begin
                q.push_back(build_word(v));
            end
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1; vld = '0; full = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        q.delete();
        m_drop = 0; m_count = 0; m_sticky = 0;
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: run did not finish, got timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        rst = 1'b1; vld = '0; full = 1'b0;
        randomize_fields();
        do_reset();
        // R10: outputs idle after reset
        phase = "R10 reset";
        step(5'b0, 0);
        step(5'b0, 0);

        // R1 R2 R3: each type alone, FIFO ready
        phase = "R1 R2 R3 single types";
        for (int k = 0; k < 5; k++) begin
            step(5'(1 << k), 0);
            step(5'b0, 0);
        end
        // back-to-back arrivals
        for (int k = 0; k < 5; k++) step(5'(1 << k), 0);
        step(5'b0, 0);

        // R9: several valids together, lowest code kept
        phase = "R9 simultaneous";
        step(5'b11010, 0);
        step(5'b11111, 0);
        step(5'b10100, 0);
        step(5'b0, 0);

        // R5 R4: two messages held while full, drained in order
        phase = "R5 R4 stall";
        step(5'b00100, 1);
        step(5'b01000, 1);
        step(5'b0, 1);
        step(5'b0, 1);
        step(5'b0, 0);
        step(5'b0, 0);
        step(5'b0, 0);

        // R6 R8: third arrival while both occupied
        phase = "R6 R8 overflow";
        step(5'b00001, 1);
        step(5'b00010, 1);
        step(5'b10000, 1);
        step(5'b0, 1);
        step(5'b0, 0);
        step(5'b0, 0);
        step(5'b0, 0);
        step(5'b0, 0);

        // random mix
        phase = "R4 R5 R6 random";
        for (int i = 0; i < 3000; i++) begin
            logic [4:0] v;
            v = ($urandom % 3 == 0) ? 5'(1 << ($urandom % 5)) : 5'b0;
            if ($urandom % 17 == 0) v = 5'($urandom);
            step(v, ($urandom % 3) == 0);
        end

        // R7: saturation of the loss counter
        phase = "R7 saturation";
        for (int i = 0; i < 65600; i++) step(5'b00100, 1);
        for (int i = 0; i < 4; i++) step(5'b0, 0);

        // R8 R10: only reset clears the flag and counter
        phase = "R8 R10 clear by reset";
        do_reset();
        step(5'b0, 0);
        step(5'b00001, 0);
        step(5'b0, 0);

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule